// File: doc/BRIEF.md
# Fractional Horizontal Pixel Decimator

This block shrinks a line of active-video pixels horizontally so the picture can be shown as a small inset. Pixels arrive with a valid strobe, and a line-start pulse marks the beginning of each line. A 6-bit reduction code sets the ratio of output pixels to input pixels: the code divided by 96. A code of 0 turns the inset off. Codes above 48 are treated as 48, which keeps every second pixel.

Pixels are chosen by a phase accumulator. Each valid input pixel adds the code to the phase. When the sum reaches 96 or more, the pixel is kept and 96 is subtracted. The line-start pulse clears the phase, so every line is sampled at the same positions.

A kept pixel appears at the output one clock after it was presented, with its own valid strobe. If the expand input is set when the pixel is kept, the same pixel is presented again on the following clock, which doubles the width of the reduced picture.

The output sequencer is a three-state machine:
- ST_IDLE: no output.
- ST_FIRST: the kept pixel is presented.
- ST_REPEAT: the kept pixel is presented a second time.

Its transitions are:
- any state → ST_FIRST on a keep.
- ST_FIRST → ST_REPEAT when the pixel was kept with expand set and no new keep arrives.
- ST_FIRST → ST_IDLE when the pixel was kept without expand and no new keep arrives.
- ST_REPEAT → ST_IDLE when no new keep arrives.

Top module: `hdecim_top`

## Requirements
- R1: Over a line of N valid pixels that starts with a line-start pulse, the block emits floor(N*c/96) pixels, where c is the effective code. With expand set, it emits twice that number.
- R2: With code 0 the block emits no valid output pixels.
- R3: Codes from 49 to 63 behave exactly as code 48.
- R4: With code 48, exactly every second valid input pixel is kept (the 2nd, 4th, …). Two consecutive valid inputs are never both kept.
- R5: A line-start pulse clears the phase before the pixel presented in the same cycle is accumulated. A pulse without a pixel still clears the phase.
- R6: The output valid strobe rises exactly one clock after the clock edge at which the kept pixel was sampled.
- R7: With expand set at the time of a keep, the same pixel value is presented with the valid strobe on the following clock as well.
- R8: The output pixel value equals the input value of the pixel that was kept.
- R9: During and right after reset, the output valid strobe is 0 and the output pixel is 0.
- R10: Cycles with the input valid strobe low do not advance the phase and produce no new output pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_code | input | 6 | Reduction code; the ratio is code/96, 0 = off, clamped to 48 |
| cfg_expand | input | 1 | Repeat each kept pixel on the next clock |
| pix_in | input | 8 | Input pixel value |
| pix_vld | input | 1 | Input pixel valid strobe |
| line_start | input | 1 | Line-start pulse; clears the phase |
| pix_out | output | 8 | Output pixel value |
| out_vld | output | 1 | Output pixel valid strobe |

## Verification
The bench builds the block with its defaults: 8-bit pixels, a 6-bit code, a denominator of 96 and a cap of 48. A 6-bit code can therefore express 49 to 63, which brings the clamp within reach. The cap equals half the denominator, so code 48 with unbroken input exercises the densest keep pattern. It also fills every cycle when expand is set. Random codes, random gaps in the valid strobe and random line lengths exercise partial phases across each line. Directed lines cover code 0, the cap, the clamp range and a line start that arrives with a non-zero residual phase.

// File: rtl/hdecim_pkg.sv
package hdecim_pkg;

    // Output sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_REPEAT = 2'd2
    } emit_state_t;

endpackage

// File: rtl/hdecim_code_clamp.sv
module hdecim_code_clamp #(
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 48
) (
    input  logic [CODE_W-1:0] code_raw,
    output logic [CODE_W-1:0] code_eff
);
    localparam int CODE_TOP = (1 << CODE_W) - 1;

    generate
        if (MAX_CODE >= CODE_TOP) begin : g_pass
            assign code_eff = code_raw;
        end else begin : g_clamp
            localparam logic [CODE_W-1:0] CAP = CODE_W'(MAX_CODE);
            always_comb begin
                if (code_raw > CAP) code_eff = CAP;
                else                code_eff = code_raw;
            end
        end
    endgenerate

endmodule

// File: rtl/hdecim_phase_acc.sv
module hdecim_phase_acc #(
    parameter int CODE_W   = 6,
    parameter int DEN      = 96,
    parameter int MAX_CODE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_eff,
    input  logic              pix_vld,
    input  logic              line_start,
    output logic              keep
);
    localparam int ACC_W = $clog2(DEN);
    localparam int SUM_W = $clog2(DEN + MAX_CODE);
    localparam logic [SUM_W-1:0] DEN_S = SUM_W'(DEN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    always_comb begin
        base = line_start ? '0 : SUM_W'(acc_q);
        sum  = base + SUM_W'(code_eff);
        wrap = (sum >= DEN_S);
        keep = pix_vld && wrap;
        if (pix_vld) begin
            if (wrap) acc_d = ACC_W'(sum - DEN_S);
            else      acc_d = ACC_W'(sum);
        end else if (line_start) begin
            acc_d = '0;
        end else begin
            acc_d = acc_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R1
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(DEN));

    // R4
    no_back_to_back_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keep |=> !keep);

    // R5
    line_start_no_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !keep);

    // R2
    code_zero_no_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_eff == '0) |-> !keep);

endmodule

// File: rtl/hdecim_emit_fsm.sv
module hdecim_emit_fsm
    import hdecim_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             keep,
    input  logic [PIX_W-1:0] pix_keep,
    input  logic             expand,
    output logic [PIX_W-1:0] pix_out,
    output logic             out_vld
);
    emit_state_t      state_q, state_d;
    logic [PIX_W-1:0] held_q;
    logic             rpt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (keep) state_d = ST_FIRST;
            ST_FIRST: begin
                if (keep)       state_d = ST_FIRST;
                else if (rpt_q) state_d = ST_REPEAT;
                else            state_d = ST_IDLE;
            end
            ST_REPEAT: begin
                if (keep) state_d = ST_FIRST;
                else      state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            rpt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (keep) begin
                held_q <= pix_keep;
                rpt_q  <= expand;
            end
        end
    end

    always_comb begin
        out_vld = (state_q != ST_IDLE);
        pix_out = held_q;
    end

    // R6
    keep_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keep |=> (out_vld && pix_out == $past(pix_keep)));

    // R7
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && rpt_q && !keep) |=> (out_vld && $stable(pix_out)));

endmodule

// File: rtl/hdecim_top.sv
module hdecim_top #(
    parameter int PIX_W    = 8,
    parameter int CODE_W   = 6,
    parameter int DEN      = 96,
    parameter int MAX_CODE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_expand,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              pix_vld,
    input  logic              line_start,
    output logic [PIX_W-1:0]  pix_out,
    output logic              out_vld
);
    logic [CODE_W-1:0] code_eff;
    logic              keep;

    hdecim_code_clamp #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_clamp (
        .code_raw (cfg_code),
        .code_eff (code_eff)
    );

    hdecim_phase_acc #(
        .CODE_W   (CODE_W),
        .DEN      (DEN),
        .MAX_CODE (MAX_CODE)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_eff   (code_eff),
        .pix_vld    (pix_vld),
        .line_start (line_start),
        .keep       (keep)
    );

    hdecim_emit_fsm #(
        .PIX_W (PIX_W)
    ) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .keep     (keep),
        .pix_keep (pix_in),
        .expand   (cfg_expand),
        .pix_out  (pix_out),
        .out_vld  (out_vld)
    );

    // R3
    clamp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code > CODE_W'(MAX_CODE)) |-> (code_eff == CODE_W'(MAX_CODE)));

    // R10
    idle_input_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_vld && !out_vld) |=> !out_vld);

endmodule

// File: tb/hdecim_top_tb.sv
module hdecim_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_code = '0;
    logic       cfg_expand = 1'b0;
    logic [7:0] pix_in = '0;
    logic       pix_vld = 1'b0;
    logic       line_start = 1'b0;
    logic [7:0] pix_out;
    logic       out_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    int       accm = 0;
    bit       pend = 0;
    bit [7:0] pend_pix = '0;
    bit       exp_v;
    bit [7:0] exp_p;
    bit       exp_rep;
    int       line_outs = 0;

    always #4 clk = ~clk;

    hdecim_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_code   (cfg_code),
        .cfg_expand (cfg_expand),
        .pix_in     (pix_in),
        .pix_vld    (pix_vld),
        .line_start (line_start),
        .pix_out    (pix_out),
        .out_vld    (out_vld)
    );

    function automatic int eff_code(input int c);
        return (c > 48) ? 48 : c;
    endfunction

    function automatic int exp_count(input int n, input int c, input bit ex);
        return ((n * eff_code(c)) / 96) * (ex ? 2 : 1);
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Drive one cycle, update model at the edge, compare at the next falling edge
    task automatic step(input bit v, input bit ls, input bit [7:0] p);
        bit k;
        int s;
        pix_vld = v; line_start = ls; pix_in = p;
        @(posedge clk);
        k = 0;
        if (ls) accm = 0;
        if (v) begin
            s = accm + eff_code(int'(cfg_code));
            if (s >= 96) begin k = 1; accm = s - 96; end
            else accm = s;
        end
        exp_rep = 0;
        if (k) begin
            exp_v = 1; exp_p = p; pend = cfg_expand; pend_pix = p;
        end else if (pend) begin
            exp_v = 1; exp_p = pend_pix; pend = 0; exp_rep = 1;
        end else begin
            exp_v = 0;
        end
        @(negedge clk);
        check(exp_rep ? "R7" : (v ? "R6" : "R10"), int'(out_vld), int'(exp_v));
        if (exp_v && out_vld) check("R8", int'(pix_out), int'(exp_p));
        if (out_vld) line_outs++;
    endtask

    // One line: line-start with first pixel, gaps with probability gap_pct
    task automatic run_line(input int n, input int c, input bit ex, input int gap_pct,
                            input string tag);
        int sent;
        cfg_code = 6'(c); cfg_expand = ex;
        line_outs = 0;
        sent = 0;
        while (sent < n) begin
            if (sent > 0 && ($urandom % 100) < gap_pct) begin
                step(0, 0, 8'($urandom));
            end else begin
                step(1, sent == 0, 8'($urandom));
                sent++;
            end
        end
        for (int i = 0; i < 3; i++) step(0, 0, 8'h00);
        check(tag, line_outs, exp_count(n, c, ex));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", int'(out_vld), 0);
        check("R9", int'(pix_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", int'(out_vld), 0);
        check("R9", int'(pix_out), 0);

        // directed corner cases
        run_line(40, 0, 0, 0, "R2");
        run_line(40, 0, 1, 20, "R2");
        run_line(40, 48, 0, 0, "R4");
        run_line(40, 48, 1, 0, "R4");
        run_line(41, 60, 0, 0, "R3");
        run_line(37, 63, 1, 30, "R3");
        run_line(96, 1, 0, 0, "R1");
        run_line(50, 47, 0, 40, "R1");

        // R5: residual phase 94 must not carry into the next line
        run_line(2, 47, 0, 0, "R5");
        run_line(3, 47, 0, 0, "R5");
        // R5: line start without a pixel clears the phase
        cfg_code = 6'd47; cfg_expand = 0; line_outs = 0;
        step(1, 1, 8'h11);
        step(0, 1, 8'h00);
        step(1, 0, 8'h22);
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
        check("R5", line_outs, 0);

        // random lines
        for (int i = 0; i < 150; i++) begin
            int c;
            c = int'($urandom % 64);
            run_line(20 + int'($urandom % 80), c, 1'($urandom), int'($urandom % 50), "R1");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule